// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This block collects four interrupt sources for a small 8-bit processor core: an external pin, a timer overflow pulse, a change detector on four upper port pins, and an analog-to-digital conversion-done pulse. Each source sets its own flag bit whether or not it is enabled. A request to the core is raised only when the global enable is set and at least one flag is paired with its own enable bit. The converter source also needs a group enable that covers all peripheral sources.

When the core accepts the request, the controller clears the global enable. On the next cycle it pulses a stack push that carries the current program counter, and a vector load that carries a fixed address. A return-from-interrupt strobe sets the global enable again and pulses a stack pop. Hardware never clears a flag. Software clears flags through the register port. If a hardware event and a software clear of the same flag happen in the same cycle, the flag is set.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, all three registers read 0x00 and irq_req, stack_push, vec_load and stack_pop are 0.
- R2: A one-cycle pulse on tmr_ovf or adc_done sets its flag at the next clock edge. This holds with every enable and the global enable cleared, and irq_req then stays 0.
- R3: The external flag is set on an edge of ext_pin that has passed two synchroniser flops. Register 2 bit 7 selects the edge: 1 for rising, 0 for falling. A pin change driven before edge k reads as 0 after edge k+1 and as 1 after edge k+2. An edge of the other polarity sets nothing.
- R4: The change flag is set whenever the synchronised port_hi differs from the reference. The reference is the synchronised value captured on a cycle with port_rd high. Once the port matches the reference, a software clear of the flag holds.
- R5: irq_req = GE & ((EXTF&EXTE) | (CHGF&CHGE) | (TMRF&TMRE) | (PE & ADCF & ADCE)). This holds for every combination of these bits.
- R6: ack while irq_req is high clears the global enable at the clock edge. After that edge, stack_push and vec_load are high for exactly one cycle, push_addr holds the pc_in value sampled on the ack cycle, and vec_addr is 0x004.
- R7: ack while irq_req is low has no effect: no push, no vector load, and the global enable is unchanged.
- R8: reti sets the global enable at the clock edge and makes stack_pop high for exactly the following cycle.
- R9: Acceptance does not clear any flag. A flag that is still set raises irq_req again after reti.
- R10: A software write that clears a flag loses to a hardware set event in the same cycle, so the flag reads 1 afterwards.
- R11: An acceptance in the same cycle as a register write to the global enable bit wins. The global enable is 0 after that edge, whatever value was written, and reti then makes it 1.
- R12: Register map: register 0 (control) has bit 7 GE, bit 6 PE, bit 5 EXTE, bit 4 CHGE, bit 3 TMRE, bit 2 EXTF, bit 1 CHGF, bit 0 TMRF. Register 1 has bit 0 ADCF. Register 2 has bit 0 ADCE and bit 7 edge select. Unused bits and register 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| tmr_ovf | input | 1 | Timer overflow pulse |
| port_hi | input | 4 | Watched port pins (asynchronous) |
| port_rd | input | 1 | Port read strobe; captures the change reference |
| adc_done | input | 1 | Conversion-complete pulse |
| pc_in | input | 13 | Current program counter, used as the return address |
| ack | input | 1 | Core accepts the pending request |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Interrupt request to the core |
| stack_push | output | 1 | Push strobe for the return address |
| push_addr | output | 13 | Return address to push |
| vec_load | output | 1 | Load the program counter with vec_addr |
| vec_addr | output | 13 | Fixed vector address |
| stack_pop | output | 1 | Pop strobe on return |

## Verification
The hardest case to produce is an acceptance that lands in the same cycle as a software write to the global enable bit. A second hard case is a hardware event that lands in the same cycle as a software clear of its flag. The bench handles both by driving all inputs on the falling edge. It arms irq_req first, then raises ack and reg_wr together, or tmr_ovf and reg_wr together, for one cycle. The enable logic is covered by a sweep of all 1024 combinations of global enable, group enable, four source enables and four flags. Flags and enables are loaded through the register port, and irq_req is compared against the formula after each combination.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam logic [1:0] ADDR_CTL  = 2'd0;
  localparam logic [1:0] ADDR_PFLG = 2'd1;
  localparam logic [1:0] ADDR_PEN  = 2'd2;

  localparam int CTL_GE   = 7;
  localparam int CTL_PE   = 6;
  localparam int CTL_EXTE = 5;
  localparam int CTL_CHGE = 4;
  localparam int CTL_TMRE = 3;
  localparam int CTL_EXTF = 2;
  localparam int CTL_CHGF = 1;
  localparam int CTL_TMRF = 0;

  localparam int PFLG_ADC = 0;
  localparam int PEN_ADC  = 0;
  localparam int PEN_EDGE = 7;

  localparam int NSRC    = 4;
  localparam int SRC_EXT = 0;
  localparam int SRC_CHG = 1;
  localparam int SRC_TMR = 2;
  localparam int SRC_ADC = 3;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q, stg_nxt;

  always_comb begin
    stg_nxt = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_nxt;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_we,
  input  logic sw_val,
  output logic flag
);
  logic flag_nxt;

  always_comb begin
    flag_nxt = sw_we ? sw_val : flag;
    if (hw_set) flag_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_nxt;
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter int PC_W = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_we,
  input  logic            sw_ge,
  input  logic            pend,
  input  logic            ack,
  input  logic            reti,
  input  logic [PC_W-1:0] pc_in,
  output logic            ge,
  output logic            irq_req,
  output logic            stack_push,
  output logic [PC_W-1:0] push_addr,
  output logic            vec_load,
  output logic            stack_pop
);
  logic            take;
  logic            ge_nxt, push_nxt, pop_nxt;
  logic [PC_W-1:0] addr_nxt;

  assign irq_req = ge & pend;
  assign take    = ack & irq_req;

  always_comb begin
    ge_nxt = ge;
    if (sw_we) ge_nxt = sw_ge;
    if (reti)  ge_nxt = 1'b1;
    if (take)  ge_nxt = 1'b0;
    push_nxt = take;
    pop_nxt  = reti & ~take;
    addr_nxt = take ? pc_in : push_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ge         <= 1'b0;
      stack_push <= 1'b0;
      vec_load   <= 1'b0;
      stack_pop  <= 1'b0;
      push_addr  <= '0;
    end else begin
      ge         <= ge_nxt;
      stack_push <= push_nxt;
      vec_load   <= push_nxt;
      stack_pop  <= pop_nxt;
      push_addr  <= addr_nxt;
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int              PC_W   = 13,
  parameter int              CHG_W  = 4,
  parameter int              SYNC_N = 2,
  parameter logic [PC_W-1:0] VECTOR = 13'h004
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             ext_pin,
  input  logic             tmr_ovf,
  input  logic [CHG_W-1:0] port_hi,
  input  logic             port_rd,
  input  logic             adc_done,
  input  logic [PC_W-1:0]  pc_in,
  input  logic             ack,
  input  logic             reti,
  output logic             irq_req,
  output logic             stack_push,
  output logic [PC_W-1:0]  push_addr,
  output logic             vec_load,
  output logic [PC_W-1:0]  vec_addr,
  output logic             stack_pop
);
  logic             ctl_we, pflg_we, pen_we;
  logic             ext_s, ext_prev_q, ext_hit, edge_rise_q, edge_rise_nxt;
  logic [CHG_W-1:0] port_s, ref_q, ref_nxt;
  logic             chg_hit;
  logic [NSRC-1:0]  hw_set, sw_we, sw_val, flag_q, en_q, en_nxt, grp_mask;
  logic             pe_q, pe_nxt, pend, gen_q;

  assign ctl_we  = reg_wr && (reg_addr == ADDR_CTL);
  assign pflg_we = reg_wr && (reg_addr == ADDR_PFLG);
  assign pen_we  = reg_wr && (reg_addr == ADDR_PEN);

  irq_sync #(.W(1), .STAGES(SYNC_N)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_pin), .q(ext_s));
  irq_sync #(.W(CHG_W), .STAGES(SYNC_N)) u_port_sync (
    .clk(clk), .rst_n(rst_n), .d(port_hi), .q(port_s));

  assign ext_hit = edge_rise_q ? (ext_s & ~ext_prev_q) : (~ext_s & ext_prev_q);
  assign chg_hit = |(port_s ^ ref_q);

  always_comb begin
    ref_nxt = port_rd ? port_s : ref_q;
    pe_nxt  = ctl_we ? reg_wdata[CTL_PE] : pe_q;
    edge_rise_nxt = pen_we ? reg_wdata[PEN_EDGE] : edge_rise_q;
    en_nxt  = en_q;
    if (ctl_we) begin
      en_nxt[SRC_EXT] = reg_wdata[CTL_EXTE];
      en_nxt[SRC_CHG] = reg_wdata[CTL_CHGE];
      en_nxt[SRC_TMR] = reg_wdata[CTL_TMRE];
    end
    if (pen_we) en_nxt[SRC_ADC] = reg_wdata[PEN_ADC];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_prev_q  <= 1'b0;
      ref_q       <= '0;
      pe_q        <= 1'b0;
      edge_rise_q <= 1'b0;
      en_q        <= '0;
    end else begin
      ext_prev_q  <= ext_s;
      ref_q       <= ref_nxt;
      pe_q        <= pe_nxt;
      edge_rise_q <= edge_rise_nxt;
      en_q        <= en_nxt;
    end
  end

  always_comb begin
    hw_set = '0;
    hw_set[SRC_EXT] = ext_hit;
    hw_set[SRC_CHG] = chg_hit;
    hw_set[SRC_TMR] = tmr_ovf;
    hw_set[SRC_ADC] = adc_done;
    sw_we  = '0;
    sw_we[SRC_EXT] = ctl_we;
    sw_we[SRC_CHG] = ctl_we;
    sw_we[SRC_TMR] = ctl_we;
    sw_we[SRC_ADC] = pflg_we;
    sw_val = '0;
    sw_val[SRC_EXT] = reg_wdata[CTL_EXTF];
    sw_val[SRC_CHG] = reg_wdata[CTL_CHGF];
    sw_val[SRC_TMR] = reg_wdata[CTL_TMRF];
    sw_val[SRC_ADC] = reg_wdata[PFLG_ADC];
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    irq_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n), .hw_set(hw_set[i]),
      .sw_we(sw_we[i]), .sw_val(sw_val[i]), .flag(flag_q[i]));
  end

  always_comb begin
    grp_mask = '1;
    grp_mask[SRC_ADC] = pe_q;
  end
  assign pend = |(flag_q & en_q & grp_mask);

  irq_seq #(.PC_W(PC_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .sw_we(ctl_we), .sw_ge(reg_wdata[CTL_GE]),
    .pend(pend), .ack(ack), .reti(reti), .pc_in(pc_in),
    .ge(gen_q), .irq_req(irq_req), .stack_push(stack_push),
    .push_addr(push_addr), .vec_load(vec_load), .stack_pop(stack_pop));

  assign vec_addr = VECTOR;

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      ADDR_CTL: begin
        reg_rdata[CTL_GE]   = gen_q;
        reg_rdata[CTL_PE]   = pe_q;
        reg_rdata[CTL_EXTE] = en_q[SRC_EXT];
        reg_rdata[CTL_CHGE] = en_q[SRC_CHG];
        reg_rdata[CTL_TMRE] = en_q[SRC_TMR];
        reg_rdata[CTL_EXTF] = flag_q[SRC_EXT];
        reg_rdata[CTL_CHGF] = flag_q[SRC_CHG];
        reg_rdata[CTL_TMRF] = flag_q[SRC_TMR];
      end
      ADDR_PFLG: reg_rdata[PFLG_ADC] = flag_q[SRC_ADC];
      ADDR_PEN: begin
        reg_rdata[PEN_ADC]  = en_q[SRC_ADC];
        reg_rdata[PEN_EDGE] = edge_rise_q;
      end
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ack,
  input logic       reti,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic       tmr_ovf,
  input logic       irq_req,
  input logic       gen,
  input logic       stack_push,
  input logic       vec_load,
  input logic       stack_pop,
  input logic       tmr_flag
);
  p_take_clears_ge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req) |=> !gen);
  p_take_pulses_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req) |=> (stack_push && vec_load));
  p_no_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && irq_req) |=> !stack_push);
  p_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !(ack && irq_req)) |=> (gen && stack_pop));
  p_tmr_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> tmr_flag);
  p_flag_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_flag && !(reg_wr && reg_addr == 2'd0)) |=> tmr_flag);
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .reti(reti), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .tmr_ovf(tmr_ovf), .irq_req(irq_req), .gen(gen_q),
  .stack_push(stack_push), .vec_load(vec_load), .stack_pop(stack_pop),
  .tmr_flag(flag_q[2]));

// File: tb/tb_irq_ctrl.sv
`timescale 1ns/1ps
module tb_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_addr;
  logic        reg_wr;
  logic [7:0]  reg_wdata;
  logic [7:0]  reg_rdata;
  logic        ext_pin, tmr_ovf, port_rd, adc_done, ack, reti;
  logic [3:0]  port_hi;
  logic [12:0] pc_in;
  logic        irq_req, stack_push, vec_load, stack_pop;
  logic [12:0] push_addr, vec_addr;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin(ext_pin),
    .tmr_ovf(tmr_ovf), .port_hi(port_hi), .port_rd(port_rd),
    .adc_done(adc_done), .pc_in(pc_in), .ack(ack), .reti(reti),
    .irq_req(irq_req), .stack_push(stack_push), .push_addr(push_addr),
    .vec_load(vec_load), .vec_addr(vec_addr), .stack_pop(stack_pop));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    rst_n = 1'b0; reg_addr = 2'd0; reg_wr = 1'b0; reg_wdata = 8'h00;
    ext_pin = 1'b0; tmr_ovf = 1'b0; port_rd = 1'b0; adc_done = 1'b0;
    ack = 1'b0; reti = 1'b0; port_hi = 4'h0; pc_in = 13'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R1 reset state
    rd(2'd0, v); check("R1 ctl", v, 8'h00);
    rd(2'd1, v); check("R1 pflg", v, 8'h00);
    rd(2'd2, v); check("R1 pen", v, 8'h00);
    check("R1 outs", {irq_req, stack_push, vec_load, stack_pop}, 4'h0);

    // R12 register map
    wr(2'd0, 8'h38); rd(2'd0, v); check("R12 ctl enables", v, 8'h38);
    wr(2'd2, 8'h81); rd(2'd2, v); check("R12 pen", v, 8'h81);
    wr(2'd2, 8'h7E); rd(2'd2, v); check("R12 pen unused", v, 8'h00);
    wr(2'd1, 8'hFF); rd(2'd1, v); check("R12 pflg", v, 8'h01);
    wr(2'd1, 8'h00);
    wr(2'd3, 8'hFF); rd(2'd3, v); check("R12 addr3", v, 8'h00);
    wr(2'd0, 8'h00);

    // R5 sweep over all enable/flag combinations
    for (int m = 0; m < 1024; m++) begin
      logic g, p, ee, ec, et, ea, fe, fc, ft, fa, exp;
      g = m[9]; p = m[8]; ee = m[7]; ec = m[6]; et = m[5]; ea = m[4];
      fe = m[3]; fc = m[2]; ft = m[1]; fa = m[0];
      wr(2'd2, {7'b0, ea});
      wr(2'd1, {7'b0, fa});
      wr(2'd0, {g, p, ee, ec, et, fe, fc, ft});
      exp = g & ((fe & ee) | (fc & ec) | (ft & et) | (p & fa & ea));
      check("R5 req", irq_req, exp);
    end
    wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00);

    // R2 flags latch with everything disabled
    tmr_ovf = 1'b1; tick(); tmr_ovf = 1'b0;
    rd(2'd0, v); check("R2 tmr flag", v, 8'h01);
    adc_done = 1'b1; tick(); adc_done = 1'b0;
    rd(2'd1, v); check("R2 adc flag", v, 8'h01);
    check("R2 no req", irq_req, 1'b0);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);

    // R3 rising-edge mode
    wr(2'd2, 8'h80);
    ext_pin = 1'b1; tick(); tick();
    rd(2'd0, v); check("R3 not yet", v[2], 1'b0);
    tick();
    rd(2'd0, v); check("R3 rising set", v[2], 1'b1);
    wr(2'd0, 8'h00);
    ext_pin = 1'b0; repeat (4) tick();
    rd(2'd0, v); check("R3 falling ignored", v[2], 1'b0);
    wr(2'd2, 8'h00);
    ext_pin = 1'b1; repeat (4) tick();
    rd(2'd0, v); check("R3 rising ignored", v[2], 1'b0);
    ext_pin = 1'b0; tick(); tick(); tick();
    rd(2'd0, v); check("R3 falling set", v[2], 1'b1);
    wr(2'd0, 8'h00);

    // R4 port change
    port_hi = 4'b0100; tick(); tick();
    rd(2'd0, v); check("R4 not yet", v[1], 1'b0);
    tick();
    rd(2'd0, v); check("R4 change set", v[1], 1'b1);
    wr(2'd0, 8'h00);
    rd(2'd0, v); check("R10 clear loses to mismatch", v[1], 1'b1);
    port_rd = 1'b1; tick(); port_rd = 1'b0;
    wr(2'd0, 8'h00);
    rd(2'd0, v); check("R4 clear holds after read", v[1], 1'b0);
    tick();
    rd(2'd0, v); check("R4 stays clear", v[1], 1'b0);

    // R10 hardware set beats same-cycle software clear
    tmr_ovf = 1'b1; wr(2'd0, 8'h00); tmr_ovf = 1'b0;
    rd(2'd0, v); check("R10 tmr", v[0], 1'b1);
    adc_done = 1'b1; wr(2'd1, 8'h00); adc_done = 1'b0;
    rd(2'd1, v); check("R10 adc", v[0], 1'b1);
    wr(2'd1, 8'h00);

    // R7 ack ignored while no request
    wr(2'd0, 8'h09);
    ack = 1'b1; pc_in = 13'h0AA; tick(); ack = 1'b0;
    check("R7 no push", {stack_push, vec_load}, 2'b00);
    rd(2'd0, v); check("R7 ge unchanged", v, 8'h09);

    // R6 acceptance
    wr(2'd0, 8'h89);
    check("R6 req", irq_req, 1'b1);
    ack = 1'b1; pc_in = 13'h123; tick(); ack = 1'b0; pc_in = 13'h0;
    check("R6 pulses", {stack_push, vec_load}, 2'b11);
    check("R6 ret addr", push_addr, 13'h123);
    check("R6 vector", vec_addr, 13'h004);
    check("R6 req drops", irq_req, 1'b0);
    rd(2'd0, v); check("R9 flag kept, ge clear", v, 8'h09);
    tick();
    check("R6 one-cycle", {stack_push, vec_load}, 2'b00);

    // R8 return
    reti = 1'b1; tick(); reti = 1'b0;
    check("R8 pop", stack_pop, 1'b1);
    rd(2'd0, v); check("R8 ge set", v[7], 1'b1);
    check("R9 req again", irq_req, 1'b1);
    tick();
    check("R8 pop one-cycle", stack_pop, 1'b0);

    // R11 acceptance vs write clearing GE
    ack = 1'b1; pc_in = 13'h055;
    wr(2'd0, 8'h09);
    ack = 1'b0;
    check("R11 push", stack_push, 1'b1);
    rd(2'd0, v); check("R11 ge clear", v[7], 1'b0);
    reti = 1'b1; tick(); reti = 1'b0;
    rd(2'd0, v); check("R11 ge set after return", v[7], 1'b1);

    // R11 acceptance vs write setting GE
    ack = 1'b1;
    wr(2'd0, 8'h89);
    ack = 1'b0;
    rd(2'd0, v); check("R11 ack beats set", v[7], 1'b0);
    check("R11 push2", stack_push, 1'b1);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule